// File: doc/BRIEF.md
# Software Interrupt Request Register

This block is a program-writable interrupt source with seven priority levels. Software posts a request at level i by setting the matching bit in the upper byte of a 16-bit register. The block continuously finds the highest pending level and shows it in the lower byte, written twice as a 3-bit field. When that level is above the current processor priority, the block raises an interrupt request at that level toward the processor, together with a fixed vector.

The request, its level and the vector stay frozen from the moment the request rises until the processor acknowledges it. After an acknowledge the request drops for one cycle. The block then re-evaluates, so any level that software has not yet cleared is requested again. Clearing request bits is left to the interrupt handler. An asynchronous power-up reset and a synchronous clear input empty the register. The clear input serves console start and the bus reset instruction.

Top module: `soft_irq_req`

## Requirements
- R1: Bit 8+i of the register (i = 1..7) is the read/write request for level i. A write stores write-data bits 15..9 into those bits, and they read back unchanged.
- R2: Write-data bits 8..0 have no effect on the register. Read bit 8 is always 0.
- R3: Read bits 7..5 and bits 3..1 each hold the highest pending level, and bits 4 and 0 read 0. This equals 0x22 times the level, and the whole low byte is 0 when no request bit is set.
- R4: The interrupt request rises only when the highest pending level is strictly greater than the 3-bit processor priority input. A level equal to the priority does not raise it. While the request is low, the level output reads 0.
- R5: Read data reflects a write on the clock edge that stores it. The request and level outputs are registered and change on the following edge.
- R6: The vector output is octal 240 for every level.
- R7: While the request is high and no acknowledge arrives, the request and its level hold. This is so even if the priority input rises or new request bits are written.
- R8: An acknowledge drops the request on the next edge. On the edge after that, the block re-evaluates the pending bits against the priority and may raise the request again.
- R9: The active-low reset (asynchronous) and the clear input (synchronous) each empty all request bits and drop the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| soft_clr | input | 1 | Synchronous clear (console start, bus reset instruction) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data; only bits 15..9 are used |
| cpu_pri | input | 3 | Current processor priority from the status word |
| irq_ack | input | 1 | Processor acknowledge of the pending request |
| rd_data | output | 16 | Register read data |
| irq_req | output | 1 | Interrupt request toward the processor |
| irq_lvl | output | 3 | Level of the pending request |
| irq_vec | output | 9 | Interrupt vector (octal 240) |

## Verification
The encoder is tried with a single request bit, with two widely separated bits, and with all seven bits plus junk in the low byte. These patterns separate a true highest-bit search from a lowest-bit or OR-based one, and show that the low byte and bit 8 are not writable. The priority comparison is tried at equality and one step below, which separates a strict compare from a non-strict one. A pending request is then hit with a priority rise and a higher new bit before acknowledge, which shows whether the output is latched. After acknowledge, the priority is held above and then dropped below the pending level, which shows the drop and re-request sequence. Reset and clear are each applied with bits set.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int unsigned PRIO_W = 3;
   typedef logic [PRIO_W-1:0] prio_t;

   // level replicated into two 3-bit fields: {l,0,l,0}
   function automatic logic [7:0] level_byte(input prio_t l);
      return {l, 1'b0, l, 1'b0};
   endfunction
endpackage

// File: rtl/pirq_store.sv
module pirq_store #(
   parameter int unsigned LEVELS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [LEVELS-1:0] wr_bits,
   output logic [LEVELS-1:0] req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     req <= '0;
      else if (clr)   req <= '0;
      else if (wr_en) req <= wr_bits;
   end

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (req == '0)); // R9
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> (req == $past(wr_bits))); // R1
endmodule

// File: rtl/pirq_encoder.sv
module pirq_encoder
   import pirq_pkg::*;
#(
   parameter int unsigned LEVELS = 7
) (
   input  logic [LEVELS-1:0] req,
   output prio_t             top
);
   logic [LEVELS-1:0] hit;

   // one-hot of the highest set bit; index k stands for level k+1
   genvar k;
   generate
      for (k = 0; k < LEVELS; k++) begin : g_hit
         if (k == LEVELS-1) begin : g_msb
            assign hit[k] = req[k];
         end else begin : g_lower
            assign hit[k] = req[k] & ~(|req[LEVELS-1:k+1]);
         end
      end
   endgenerate

   always_comb begin
      top = '0;
      for (int j = 0; j < LEVELS; j++) begin
         if (hit[j]) top = top | prio_t'(j + 1);
      end
   end

   always_comb begin
      AST_TOP_ZERO: assert ((top == '0) == (req == '0)); // R3
   end
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
   import pirq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  ack,
   input  prio_t top,
   input  prio_t cpu_pri,
   output logic  irq_o,
   output prio_t lvl_o
);
   logic grant;
   assign grant = (top > cpu_pri);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         lvl_o <= '0;
      end else if (clr || ack) begin
         irq_o <= 1'b0;
         lvl_o <= '0;
      end else if (!irq_o) begin
         irq_o <= grant;
         lvl_o <= grant ? top : prio_t'(0);
      end
   end

   AST_RISE_ABOVE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (lvl_o > $past(cpu_pri))); // R4
   AST_IDLE_LVL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (lvl_o == '0)); // R4
   AST_HOLD_TILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack && !clr) |=> (irq_o && $stable(lvl_o))); // R7
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !irq_o); // R8
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !irq_o); // R9
endmodule

// File: rtl/soft_irq_req.sv
module soft_irq_req
   import pirq_pkg::*;
#(
   parameter int unsigned LEVELS = 7,
   parameter int unsigned VEC_W  = 9,
   parameter logic [VEC_W-1:0] VECTOR = 9'o240
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             wr_en,
   input  logic [15:0]      wr_data,
   input  logic [2:0]       cpu_pri,
   input  logic             irq_ack,
   output logic [15:0]      rd_data,
   output logic             irq_req,
   output logic [2:0]       irq_lvl,
   output logic [VEC_W-1:0] irq_vec
);
   localparam int unsigned BASE = 9;           // bit of level 1
   localparam int unsigned TOPB = BASE + LEVELS - 1;
   localparam int unsigned PAD  = 7 - LEVELS;

   generate
      if (LEVELS < 1 || LEVELS > 7) begin : g_bad_levels
         $error("soft_irq_req: LEVELS must be 1..7");
      end
      if (VEC_W < 9) begin : g_bad_vec
         $error("soft_irq_req: VEC_W too narrow for vector");
      end
   endgenerate

   logic [LEVELS-1:0] req;
   prio_t             top;
   logic              unused_wr;

   pirq_store #(.LEVELS(LEVELS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_clr),
      .wr_en   (wr_en),
      .wr_bits (wr_data[TOPB:BASE]),
      .req     (req)
   );

   pirq_encoder #(.LEVELS(LEVELS)) u_enc (
      .req (req),
      .top (top)
   );

   pirq_arbiter u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_clr),
      .ack     (irq_ack),
      .top     (top),
      .cpu_pri (cpu_pri),
      .irq_o   (irq_req),
      .lvl_o   (irq_lvl)
   );

   generate
      if (PAD > 0) begin : g_pad
         assign rd_data[15:TOPB+1] = '0;
         assign unused_wr = ^{wr_data[8:0], wr_data[15:TOPB+1]};
      end else begin : g_full
         assign unused_wr = ^wr_data[8:0];
      end
   endgenerate

   assign rd_data[TOPB:BASE] = req;
   assign rd_data[8]         = 1'b0;
   assign rd_data[7:0]       = level_byte(top);
   assign irq_vec            = VECTOR;

   AST_LVL_MATCHES_TOP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> (irq_lvl == $past(rd_data[7:5]))); // R5
endmodule

// File: tb/test_soft_irq_req.sv
module test_soft_irq_req;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_clr = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [2:0]  cpu_pri = '0;
   logic        irq_ack = 1'b0;
   logic [15:0] rd_data;
   logic        irq_req;
   logic [2:0]  irq_lvl;
   logic [8:0]  irq_vec;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk; // 125 MHz

   soft_irq_req i_soft_irq_req (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_en),
      .wr_data(wr_data), .cpu_pri(cpu_pri), .irq_ack(irq_ack),
      .rd_data(rd_data), .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected low byte from highest level
   function automatic logic [15:0] exp_rd(input logic [6:0] bits);
      logic [2:0] l = 3'd0;
      for (int i = 0; i < 7; i++) if (bits[i]) l = 3'(i + 1);
      return {bits, 1'b0, l, 1'b0, l, 1'b0};
   endfunction

   task automatic write(input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic clear_pulse();
      @(negedge clk); soft_clr = 1'b1;
      @(negedge clk); soft_clr = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 reset rd", rd_data, 16'h0000);
      chk("R9 reset irq", {15'd0, irq_req}, 16'd0);
      chk("R4 reset lvl", {13'd0, irq_lvl}, 16'd0);
   endtask

   task automatic t_single();
      cpu_pri = 3'd0;
      write(16'h0800);                 // level 3
      chk("R1 R3 single rd", rd_data, exp_rd(7'b0000100));
      chk("R5 irq not yet", {15'd0, irq_req}, 16'd0);
      @(negedge clk);
      chk("R5 irq one edge later", {15'd0, irq_req}, 16'd1);
      chk("R5 lvl 3", {13'd0, irq_lvl}, 16'd3);
      chk("R6 vector", {7'd0, irq_vec}, 16'o240);
      clear_pulse();
   endtask

   task automatic t_mixed();
      write(16'h25FF);                 // levels 2,5 plus junk low byte and bit 8
      chk("R2 R3 mixed rd", rd_data, 16'h24AA);
      @(negedge clk);
      chk("R3 mixed lvl 5", {13'd0, irq_lvl}, 16'd5);
      chk("R6 vector lvl5", {7'd0, irq_vec}, 16'o240);
      clear_pulse();
      write(16'hFFFF);
      chk("R1 R2 R3 all rd", rd_data, 16'hFEEE);
      @(negedge clk);
      chk("R3 all lvl 7", {13'd0, irq_lvl}, 16'd7);
      clear_pulse();
   endtask

   task automatic t_priority();
      cpu_pri = 3'd4;
      write(16'h1000);                 // level 4 equals priority
      repeat (3) @(negedge clk);
      chk("R4 equal no irq", {15'd0, irq_req}, 16'd0);
      chk("R4 equal lvl 0", {13'd0, irq_lvl}, 16'd0);
      cpu_pri = 3'd3;
      @(negedge clk);
      chk("R4 above irq", {15'd0, irq_req}, 16'd1);
      chk("R4 above lvl", {13'd0, irq_lvl}, 16'd4);
   endtask

   task automatic t_hold_ack();
      cpu_pri = 3'd7;
      write(16'h9000);                 // add level 7 while level 4 pending
      repeat (2) @(negedge clk);
      chk("R7 hold irq", {15'd0, irq_req}, 16'd1);
      chk("R7 hold lvl", {13'd0, irq_lvl}, 16'd4);
      chk("R1 rd after add", rd_data, exp_rd(7'b1001000));
      ack_pulse();
      chk("R8 ack drops", {15'd0, irq_req}, 16'd0);
      @(negedge clk);
      chk("R8 masked stays low", {15'd0, irq_req}, 16'd0);
      cpu_pri = 3'd0;
      @(negedge clk);
      chk("R8 re-request", {15'd0, irq_req}, 16'd1);
      chk("R8 re-request lvl", {13'd0, irq_lvl}, 16'd7);
   endtask

   task automatic t_clear();
      clear_pulse();
      chk("R9 clear rd", rd_data, 16'h0000);
      chk("R9 clear irq", {15'd0, irq_req}, 16'd0);
      write(16'h4000);
      @(negedge clk);
      chk("R1 set before reset", rd_data, exp_rd(7'b0100000));
      #1 rst_n = 1'b0;
      #2;
      chk("R9 async reset rd", rd_data, 16'h0000);
      chk("R9 async reset irq", {15'd0, irq_req}, 16'd0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_mixed();
      t_priority();
      t_hold_ack();
      t_clear();
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule